// File: doc/BRIEF.md
# DMA Channel Loop Address Engine

This block is the sequencing core of a single channel in a descriptor-driven DMA engine. It holds one transfer descriptor: source and destination addresses, signed per-beat offsets, a beat size, a per-minor-loop byte count, one signed minor-loop offset with a separate enable for each side, signed last-address adjustments, and a beginning iteration count. Each accepted request runs one minor loop. A minor loop is a run of beats issued on a valid/ready beat port, and every beat carries one source address, one destination address and the size.

When a minor loop ends, the engine updates both addresses. If the loop was not the last one of the major loop, the minor-loop offset is added on each enabled side. If it was the last one, the last-address adjustment is added instead. The engine also counts iterations down, sets a sticky done flag at the end of each major loop and can raise one-cycle interrupt pulses at the half point and at major completion. The address left at the end of a major loop is where the next major loop starts. Software picks the last adjustment to choose between running on through memory and returning to the start.

Top module: `dma_loop_engine`

## Requirements
- R1: Each minor loop issues `cfg_nbytes >> cfg_size` beats. The size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes (3 = 8 bytes), and `cfg_nbytes` must be a nonzero multiple of the beat size. While `bt_valid` is high and `bt_ready` is low, `bt_valid`, `bt_saddr`, `bt_daddr` and `bt_size` hold their values. `bt_valid` rises on the clock edge after the request is taken.
- R2: After every accepted beat, the source address advances by `cfg_soff` and the destination address by `cfg_doff`. Both offsets are 16-bit signed values, sign-extended, and the result wraps modulo 2^32.
- R3: At the end of a minor loop that is not the last of its major loop, the 20-bit signed `cfg_mloff` is added to the source address when `cfg_smloe` is 1 and to the destination address when `cfg_dmloe` is 1. This is in addition to that beat's per-beat offset.
- R4: At the end of the last minor loop, no minor-loop offset is applied. The 32-bit `cfg_slast` and `cfg_dlast` are added instead, and the resulting addresses are where the next major loop begins.
- R5: An accepted configuration sets `citer` to `cfg_biter` (which must be at least 1). `citer` drops by one after each minor loop and reloads from the beginning count when it would reach zero.
- R6: When a major loop completes, `done` goes to 1 and stays there until `done_clr` is pulsed. In the same cycle, `irq_major` pulses for one cycle if major interrupts were enabled.
- R7: `irq_half` pulses for one cycle when a minor loop leaves the count equal to `cfg_biter >> 1`, provided half interrupts were enabled and that value is nonzero.
- R8: When `cfg_req_stop` was set, completing a major loop stops the engine from taking requests, so no further beats appear until a new configuration is accepted.
- R9: A configuration write is accepted only while `done` is 0 and no minor loop is running. Otherwise it is ignored, and the addresses and `citer` are left as they were.
- R10: A request that arrives during a minor loop is held and served right after that minor loop ends. Several such requests merge into one.
- R11: After reset, all outputs are 0 and requests are ignored until a configuration has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_saddr | input | 32 | Start source address |
| cfg_daddr | input | 32 | Start destination address |
| cfg_soff | input | 16 | Signed source offset per beat |
| cfg_doff | input | 16 | Signed destination offset per beat |
| cfg_size | input | 2 | Beat size code (log2 bytes) |
| cfg_nbytes | input | 16 | Bytes per minor loop |
| cfg_mloff | input | 20 | Signed minor-loop offset |
| cfg_smloe | input | 1 | Apply minor-loop offset to source |
| cfg_dmloe | input | 1 | Apply minor-loop offset to destination |
| cfg_slast | input | 32 | Signed source adjustment at major end |
| cfg_dlast | input | 32 | Signed destination adjustment at major end |
| cfg_biter | input | 16 | Beginning iteration count |
| cfg_irq_major_en | input | 1 | Enable major-complete pulse |
| cfg_irq_half_en | input | 1 | Enable half-point pulse |
| cfg_req_stop | input | 1 | Stop taking requests after major end |
| done_clr | input | 1 | Clear the done flag |
| req | input | 1 | Transfer request, one minor loop each |
| bt_valid | output | 1 | Beat valid |
| bt_ready | input | 1 | Beat accepted |
| bt_saddr | output | 32 | Current source address |
| bt_daddr | output | 32 | Current destination address |
| bt_size | output | 2 | Beat size code |
| citer | output | 16 | Current iteration count |
| done | output | 1 | Major loop done flag |
| irq_major | output | 1 | Major-complete pulse |
| irq_half | output | 1 | Half-point pulse |

## Verification
The bench aims at the boundary between the last minor loop and the others. If a design applied the minor offset on the final loop, or the last adjustment one loop early, the starting address of the next major loop would be off by exactly that offset. The bench uses negative offsets and a start address near zero to check sign extension and wrap; a design that zero-extends the offsets produces addresses far from the expected ones. It also stalls the beat port at random. It sends requests during a running minor loop to check that they are held and merged, with no extra minor loop and none lost. It writes a configuration while `done` is set, which must leave the state untouched, and it sends requests after a stop-on-completion major loop, which must produce no beats.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;
  typedef enum logic {ST_IDLE, ST_BEAT} dma_st_e;

  function automatic int unsigned beat_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int MLO_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              beat,
  input  logic              minor_end,
  input  logic              major_end,
  input  logic [OFF_W-1:0]  beat_off,
  input  logic [MLO_W-1:0]  minor_off,
  input  logic              minor_en,
  input  logic [ADDR_W-1:0] last_adj,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] off_x, mlo_x, stepped, next_addr;

  assign off_x   = {{(ADDR_W-OFF_W){beat_off[OFF_W-1]}}, beat_off};
  assign mlo_x   = {{(ADDR_W-MLO_W){minor_off[MLO_W-1]}}, minor_off};
  assign stepped = addr_q + off_x;

  always_comb begin
    next_addr = stepped;
    if (minor_end) begin
      if (major_end)     next_addr = stepped + last_adj;
      else if (minor_en) next_addr = stepped + mlo_x;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_addr;
    else if (beat) addr_q <= next_addr;
  end
endmodule

// File: rtl/dma_iter_ctrl.sv
module dma_iter_ctrl #(
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ITER_W-1:0] load_iter,
  input  logic [ITER_W-1:0] biter,
  input  logic              minor_end,
  input  logic              major_en,
  input  logic              half_en,
  input  logic              done_clr,
  output logic              last_iter,
  output logic [ITER_W-1:0] citer_q,
  output logic              done_q,
  output logic              irq_major_q,
  output logic              irq_half_q
);
  logic [ITER_W-1:0] half_pt, dec;

  assign half_pt   = biter >> 1;
  assign dec       = citer_q - 1'b1;
  assign last_iter = (citer_q == ITER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      citer_q     <= '0;
      done_q      <= 1'b0;
      irq_major_q <= 1'b0;
      irq_half_q  <= 1'b0;
    end else begin
      irq_major_q <= 1'b0;
      irq_half_q  <= 1'b0;
      if (done_clr) done_q <= 1'b0;
      if (load) begin
        citer_q <= load_iter;
      end else if (minor_end) begin
        irq_half_q <= half_en && (half_pt != '0) && (dec == half_pt);
        if (last_iter) begin
          citer_q     <= biter;
          done_q      <= 1'b1;
          irq_major_q <= major_en;
        end else begin
          citer_q <= dec;
        end
      end
    end
  end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int MLO_W  = 20,
  parameter int NB_W   = 16,
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_saddr,
  input  logic [ADDR_W-1:0] cfg_daddr,
  input  logic [OFF_W-1:0]  cfg_soff,
  input  logic [OFF_W-1:0]  cfg_doff,
  input  logic [1:0]        cfg_size,
  input  logic [NB_W-1:0]   cfg_nbytes,
  input  logic [MLO_W-1:0]  cfg_mloff,
  input  logic              cfg_smloe,
  input  logic              cfg_dmloe,
  input  logic [ADDR_W-1:0] cfg_slast,
  input  logic [ADDR_W-1:0] cfg_dlast,
  input  logic [ITER_W-1:0] cfg_biter,
  input  logic              cfg_irq_major_en,
  input  logic              cfg_irq_half_en,
  input  logic              cfg_req_stop,
  input  logic              done_clr,
  input  logic              req,
  output logic              bt_valid,
  input  logic              bt_ready,
  output logic [ADDR_W-1:0] bt_saddr,
  output logic [ADDR_W-1:0] bt_daddr,
  output logic [1:0]        bt_size,
  output logic [ITER_W-1:0] citer,
  output logic              done,
  output logic              irq_major,
  output logic              irq_half
);
  localparam int NSIDE = 2;

  dma_st_e           state_q;
  logic              cfg_ok, erq_q, pend_q;
  logic [NB_W-1:0]   left_q, bb;
  logic [OFF_W-1:0]  soff_q, doff_q;
  logic [1:0]        size_q;
  logic [NB_W-1:0]   nb_q;
  logic [MLO_W-1:0]  mlo_q;
  logic              smloe_q, dmloe_q, ime_q, ihe_q, stop_q;
  logic [ADDR_W-1:0] slast_q, dlast_q;
  logic [ITER_W-1:0] biter_q;
  logic              cfg_acc, start, beat, minor_end, last_iter;

  logic [NSIDE-1:0][ADDR_W-1:0] ld_v, last_v, addr_v;
  logic [NSIDE-1:0][OFF_W-1:0]  off_v;
  logic [NSIDE-1:0]             mloe_v;

  assign bb        = NB_W'(beat_bytes(size_q));
  assign cfg_acc   = cfg_we && !done && (state_q == ST_IDLE);
  assign start     = (state_q == ST_IDLE) && cfg_ok && erq_q && (req || pend_q) && !cfg_acc;
  assign beat      = (state_q == ST_BEAT) && bt_ready;
  assign minor_end = beat && (left_q <= bb);

  always_ff @(posedge clk) begin
    if (rst) begin
      soff_q <= '0; doff_q <= '0; size_q <= '0; nb_q <= '0; mlo_q <= '0;
      smloe_q <= 1'b0; dmloe_q <= 1'b0; ime_q <= 1'b0; ihe_q <= 1'b0; stop_q <= 1'b0;
      slast_q <= '0; dlast_q <= '0; biter_q <= '0; cfg_ok <= 1'b0;
    end else if (cfg_acc) begin
      soff_q  <= cfg_soff;   doff_q  <= cfg_doff;
      size_q  <= cfg_size;   nb_q    <= cfg_nbytes;
      mlo_q   <= cfg_mloff;  smloe_q <= cfg_smloe;  dmloe_q <= cfg_dmloe;
      slast_q <= cfg_slast;  dlast_q <= cfg_dlast;  biter_q <= cfg_biter;
      ime_q   <= cfg_irq_major_en; ihe_q <= cfg_irq_half_en; stop_q <= cfg_req_stop;
      cfg_ok  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      erq_q   <= 1'b0;
      pend_q  <= 1'b0;
      left_q  <= '0;
    end else if (cfg_acc) begin
      erq_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (start) begin
        state_q <= ST_BEAT;
        left_q  <= nb_q;
        pend_q  <= 1'b0;
      end else if ((state_q == ST_BEAT) && erq_q && req) begin
        pend_q <= 1'b1;
      end
      if (beat) begin
        left_q <= left_q - bb;
        if (minor_end) state_q <= ST_IDLE;
      end
      if (minor_end && last_iter && stop_q) begin
        erq_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  assign ld_v[0]   = cfg_saddr;  assign ld_v[1]   = cfg_daddr;
  assign last_v[0] = slast_q;    assign last_v[1] = dlast_q;
  assign off_v[0]  = soff_q;     assign off_v[1]  = doff_q;
  assign mloe_v[0] = smloe_q;    assign mloe_v[1] = dmloe_q;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MLO_W(MLO_W)) u_addr (
      .clk       (clk),
      .rst       (rst),
      .load      (cfg_acc),
      .load_addr (ld_v[g]),
      .beat      (beat),
      .minor_end (minor_end),
      .major_end (last_iter),
      .beat_off  (off_v[g]),
      .minor_off (mlo_q),
      .minor_en  (mloe_v[g]),
      .last_adj  (last_v[g]),
      .addr_q    (addr_v[g])
    );
  end

  dma_iter_ctrl #(.ITER_W(ITER_W)) u_iter (
    .clk         (clk),
    .rst         (rst),
    .load        (cfg_acc),
    .load_iter   (cfg_biter),
    .biter       (biter_q),
    .minor_end   (minor_end),
    .major_en    (ime_q),
    .half_en     (ihe_q),
    .done_clr    (done_clr),
    .last_iter   (last_iter),
    .citer_q     (citer),
    .done_q      (done),
    .irq_major_q (irq_major),
    .irq_half_q  (irq_half)
  );

  assign bt_valid = (state_q == ST_BEAT);
  assign bt_saddr = addr_v[0];
  assign bt_daddr = addr_v[1];
  assign bt_size  = size_q;
endmodule

// File: rtl/dma_loop_chk.sv
module dma_loop_chk #(
  parameter int ADDR_W = 32,
  parameter int ITER_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bt_valid,
  input logic              bt_ready,
  input logic [ADDR_W-1:0] bt_saddr,
  input logic [ADDR_W-1:0] bt_daddr,
  input logic [1:0]        bt_size,
  input logic              cfg_we,
  input logic              done,
  input logic              irq_major,
  input logic              irq_half,
  input logic [ITER_W-1:0] citer,
  input logic [ITER_W-1:0] biter_q,
  input logic              cfg_ok,
  input logic              erq_q
);
  // R1
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bt_valid && !bt_ready |=> bt_valid && $stable(bt_saddr) && $stable(bt_daddr) && $stable(bt_size));
  // R6
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    irq_major |-> done);
  // R7
  half_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_half |=> !irq_half);
  // R5
  citer_nz_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |-> citer != '0);
  // R9
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    done && cfg_we |=> $stable(biter_q));
  // R8
  req_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !erq_q && !bt_valid |=> !bt_valid);
endmodule

bind dma_loop_engine dma_loop_chk #(.ADDR_W(ADDR_W), .ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst(rst), .bt_valid(bt_valid), .bt_ready(bt_ready),
  .bt_saddr(bt_saddr), .bt_daddr(bt_daddr), .bt_size(bt_size),
  .cfg_we(cfg_we), .done(done), .irq_major(irq_major), .irq_half(irq_half),
  .citer(citer), .biter_q(biter_q), .cfg_ok(cfg_ok), .erq_q(erq_q)
);

// File: tb/dma_loop_engine_bench.sv
module dma_loop_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_smloe = 0, cfg_dmloe = 0, cfg_ime = 0, cfg_ihe = 0, cfg_stop = 0;
  logic [31:0] cfg_saddr = 0, cfg_daddr = 0, cfg_slast = 0, cfg_dlast = 0;
  logic [15:0] cfg_soff = 0, cfg_doff = 0, cfg_nbytes = 0, cfg_biter = 0;
  logic [1:0]  cfg_size = 0;
  logic [19:0] cfg_mloff = 0;
  logic done_clr = 0, req = 0, bt_ready = 0;
  logic bt_valid, done, irq_major, irq_half;
  logic [31:0] bt_saddr, bt_daddr;
  logic [1:0]  bt_size;
  logic [15:0] citer;

  int checks = 0, errors = 0;
  logic [31:0] ms, md;
  logic [15:0] mc;
  logic exp_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_loop_engine u_dma_loop_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_saddr(cfg_saddr), .cfg_daddr(cfg_daddr),
    .cfg_soff(cfg_soff), .cfg_doff(cfg_doff), .cfg_size(cfg_size), .cfg_nbytes(cfg_nbytes),
    .cfg_mloff(cfg_mloff), .cfg_smloe(cfg_smloe), .cfg_dmloe(cfg_dmloe),
    .cfg_slast(cfg_slast), .cfg_dlast(cfg_dlast), .cfg_biter(cfg_biter),
    .cfg_irq_major_en(cfg_ime), .cfg_irq_half_en(cfg_ihe), .cfg_req_stop(cfg_stop),
    .done_clr(done_clr), .req(req), .bt_valid(bt_valid), .bt_ready(bt_ready),
    .bt_saddr(bt_saddr), .bt_daddr(bt_daddr), .bt_size(bt_size), .citer(citer),
    .done(done), .irq_major(irq_major), .irq_half(irq_half)
  );

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] sx20(input logic [19:0] v);
    return {{12{v[19]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic apply_cfg(input logic [31:0] sa, input logic [31:0] da,
                           input logic [15:0] so, input logic [15:0] dof,
                           input logic [1:0] sz, input logic [15:0] nb,
                           input logic [19:0] mlo, input logic se, input logic de,
                           input logic [31:0] sl, input logic [31:0] dl,
                           input logic [15:0] bi, input logic im, input logic ih,
                           input logic st);
    cfg_saddr = sa; cfg_daddr = da; cfg_soff = so; cfg_doff = dof; cfg_size = sz;
    cfg_nbytes = nb; cfg_mloff = mlo; cfg_smloe = se; cfg_dmloe = de;
    cfg_slast = sl; cfg_dlast = dl; cfg_biter = bi; cfg_ime = im; cfg_ihe = ih;
    cfg_stop = st; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    if (!exp_done) begin
      ms = sa; md = da; mc = bi;
    end
    chk("R9 cfg src addr", bt_saddr, ms);
    chk("R9 cfg dst addr", bt_daddr, md);
    chk("R5 citer after cfg", 32'(citer), 32'(mc));
  endtask

  task automatic clear_done();
    done_clr = 1;
    @(negedge clk);
    done_clr = 0;
    exp_done = 0;
    chk("R6 done cleared", 32'(done), 0);
  endtask

  // one minor loop: optionally raise req; extra = another req mid-loop (R10)
  task automatic do_minor(input logic use_req, input logic extra);
    int nbeat, got, guard;
    logic rdy, maj, half;
    logic [15:0] newc;
    nbeat = int'(cfg_nbytes >> cfg_size);
    got = 0; guard = 0; maj = 0; half = 0;
    if (use_req) req = 1;
    @(negedge clk);
    req = 0;
    while (got < nbeat && guard < 400) begin
      chk("R1 beat valid", 32'(bt_valid), 1);
      chk("R2 beat src addr", bt_saddr, ms);
      chk("R2 beat dst addr", bt_daddr, md);
      chk("R1 beat size", 32'(bt_size), 32'(cfg_size));
      rdy = ($urandom % 3) != 0;
      bt_ready = rdy;
      if (extra && guard == 0) req = 1;
      @(negedge clk);
      req = 0;
      if (rdy) begin
        got++;
        ms = ms + sx16(cfg_soff);
        md = md + sx16(cfg_doff);
        if (got == nbeat) begin
          newc = mc - 16'd1;
          half = cfg_ihe && ((cfg_biter >> 1) != 0) && (newc == (cfg_biter >> 1));
          if (mc == 16'd1) begin
            ms = ms + cfg_slast; md = md + cfg_dlast; mc = cfg_biter; maj = 1;
          end else begin
            if (cfg_smloe) ms = ms + sx20(cfg_mloff);
            if (cfg_dmloe) md = md + sx20(cfg_mloff);
            mc = newc;
          end
        end
      end
      guard++;
    end
    bt_ready = 0;
    if (maj) exp_done = 1;
    chk("R1 beat count / valid low", 32'(bt_valid), 0);
    chk("R3 R4 src addr after minor", bt_saddr, ms);
    chk("R3 R4 dst addr after minor", bt_daddr, md);
    chk("R5 citer after minor", 32'(citer), 32'(mc));
    chk("R6 done", 32'(done), 32'(exp_done));
    chk("R6 irq_major", 32'(irq_major), 32'(maj && cfg_ime));
    chk("R7 irq_half", 32'(irq_half), 32'(half));
  endtask

  task automatic idle_check(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, 32'(bt_valid), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    exp_done = 0; ms = 0; md = 0; mc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset bt_valid", 32'(bt_valid), 0);
    chk("R11 reset addr", bt_saddr | bt_daddr, 0);
    chk("R11 reset citer", 32'(citer), 0);
    chk("R11 reset flags", 32'({done, irq_major, irq_half}), 0);
    req = 1; @(negedge clk); req = 0;
    idle_check("R11 req before cfg", 3);

    // directed: source returns each minor loop, destination runs on
    apply_cfg(32'h1000, 32'h2000, 16'd4, 16'd4, 2'd2, 16'd8, 20'hFFFF8, 1, 0,
              32'hFFFF_FFF0, 32'h0, 16'd3, 1, 1, 0);
    do_minor(1, 0);
    do_minor(1, 0);   // R7 half at citer 1
    do_minor(1, 0);   // R4 last adjustment, R6 done
    chk("R4 src start of next major", bt_saddr, 32'h0FF8);
    do_minor(1, 1);   // R10 request held
    do_minor(0, 0);   // served from pending
    idle_check("R10 merged pending", 4);

    // R9 config while done is ignored
    apply_cfg(32'hDEAD_0000, 32'hBEEF_0000, 16'd1, 16'd1, 2'd0, 16'd1, 20'h0, 0, 0,
              32'h0, 32'h0, 16'd9, 0, 0, 0);
    chk("R9 biter unchanged", 32'(citer), 32'(mc));
    clear_done();

    // R8 stop on completion, R2 negative offset with wrap below zero
    apply_cfg(32'h0000_0002, 32'h0000_0010, 16'hFFFF, 16'hFFFE, 2'd0, 16'd3, 20'h0, 0, 0,
              32'h0, 32'h0, 16'd1, 1, 0, 1);
    do_minor(1, 0);
    chk("R2 wrap src", bt_saddr, 32'hFFFF_FFFF);
    req = 1; @(negedge clk); req = 0;
    idle_check("R8 requests blocked", 4);
    chk("R8 citer unchanged", 32'(citer), 32'(mc));
    clear_done();

    // random descriptors
    for (int t = 0; t < 14; t++) begin
      logic [1:0] sz;
      logic [15:0] bi;
      sz = 2'($urandom % 3);
      bi = 16'(1 + $urandom % 6);
      apply_cfg($urandom, $urandom, 16'($urandom), 16'($urandom), sz,
                16'((1 + $urandom % 4) << sz), 20'($urandom),
                1'($urandom), 1'($urandom), $urandom, $urandom, bi,
                1'($urandom), 1'($urandom), 0);
      for (int k = 0; k <= int'(bi); k++) do_minor(1, (k == 1) ? 1'b0 : 1'b0);
      clear_done();
    end
    summary();
  end
endmodule